// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits on the synchronous side of a chip and drives an external asynchronous byte-wide static memory (8192 words by default). A host presents one request at a time (address, write data and a write flag) on a valid/ready handshake. The sequencer turns each request into active-low chip-select, write-strobe and output-enable pins, drives the shared data pins during writes, and for reads returns the sampled byte together with a one-cycle completion pulse. Writes also raise the completion pulse.

Every timing figure of the memory is a nanosecond parameter. The block divides each one by the clock period and rounds up, so one netlist can meet a fast or a slow memory grade. Chip select always falls one cycle before the write strobe and both rise together. The address is held from acceptance until the next acceptance, so it never moves while both strobes are low. An external write-protect input (for example a supply-fail detector) stops new requests from being accepted. An access already in progress still runs to its end.

Top module: `sram_seq`

## Requirements
- R1: After reset, memCeN, memWeN and memOeN are 1, rspDone is 0, the data pins are released, and reqReady is 1 when writeProtect is 0.
- R2: reqReady is 1 only in an idle cycle with writeProtect at 0. A request is taken at a rising edge where reqValid and reqReady are both 1. Raising writeProtect during an access does not cut that access short.
- R3: A write takes one setup cycle (memCeN=0, memWeN=1), then WE_CYC cycles with memCeN=0 and memWeN=0. After that memCeN and memWeN rise in the same cycle. memOeN stays 1 for the whole write.
- R4: The write byte is captured at acceptance. It is driven on memDq through every cycle with memWeN=0 and through the one hold cycle after it. At all other times memDq is released.
- R5: After the write strobes rise, the block spends REC_CYC cycles with all strobes at 1 and then accepts again. REC_CYC is at least the chip-select recovery time, and it is also large enough that the whole write lasts at least the write cycle time.
- R6: memAddr takes the request address at acceptance and does not change during any cycle with memCeN=0.
- R7: A read holds memCeN=0, memOeN=0 and memWeN=1 for RD_CYC cycles. The byte on memDq is sampled at the end of the last of those cycles.
- R8: The cycle after a read's strobes rise, rspDone is 1 for exactly one cycle and rspRdata holds the sampled byte. rspRdata then keeps that byte until the next read completes.
- R9: Between two accesses there is at least one cycle with all three strobes at 1. rspDone is only ever 1 while all strobes are 1.
- R10: Each cycle count is ceil(ns*1000/CLK_PERIOD_PS), with a minimum of 1. WE_CYC is the largest of these: the write pulse count, the chip-select-to-end count minus one, the address-to-end count minus one, and the data-setup count. RD_CYC is the largest of the read cycle, address access, chip-select access and output-enable access counts. With the defaults at 10 ns this gives WE_CYC=6, REC_CYC=2 and RD_CYC=7.
- R11: For a write, rspDone is 1 for one cycle, in the hold cycle (the first cycle after the write strobes rise).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be accepted this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | DATA_W | Write byte |
| writeProtect | input | 1 | Blocks acceptance of new requests |
| rspDone | output | 1 | One-cycle completion pulse |
| rspRdata | output | DATA_W | Last read byte |
| memCeN | output | 1 | Memory chip select, active low |
| memWeN | output | 1 | Memory write strobe, active low |
| memOeN | output | 1 | Memory output enable, active low |
| memAddr | output | ADDR_W | Memory address |
| memDq | inout | DATA_W | Memory data pins |

## Verification
A corrupted state or counter in the sequencer shows up as a strobe pattern that differs from the reference. A write pulse one cycle short or long, or a read window one cycle off, changes a pin on the very cycle where the edge belongs. The bench compares every strobe on every clock, so such an error is reported within one cycle. A wrong address or data latch shows up in the first strobe-active cycle of that access. A wrong capture moment shows up as a wrong byte at the completion pulse. A broken protect gate shows up as a request being taken in a cycle where the reference keeps reqReady low.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  // strobes handed from the control FSM to the datapath
  typedef struct packed {
    logic ceN;
    logic weN;
    logic oeN;
    logic busDrive;
    logic capture;
    logic load;
  } seqStrobe_t;

  // whole cycles needed to cover a nanosecond figure, never below one
  function automatic int cyclesFor(input int ns, input int periodPs);
    int c;
    c = (ns * 1000 + periodPs - 1) / periodPs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int WE_CYC  = 6,
  parameter int REC_CYC = 2,
  parameter int RD_CYC  = 7,
  parameter int CNT_W   = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       writeProtect,
  output logic       reqReady,
  output logic       rspDone,
  output seqStrobe_t strobe
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_WSET, ST_WPULSE, ST_WREC, ST_READ, ST_GAP
  } seqState_t;

  localparam logic [CNT_W-1:0] WE_LAST  = CNT_W'(WE_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LAST = CNT_W'(REC_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LAST  = CNT_W'(RD_CYC - 1);

  seqState_t        state;
  logic [CNT_W-1:0] cnt;
  logic             accept;
  logic             cntZero;
  logic             firstRec;

  assign reqReady = (state == ST_IDLE) && !writeProtect;
  assign accept   = reqValid && reqReady;
  assign cntZero  = (cnt == '0);
  assign firstRec = (state == ST_WREC) && (cnt == REC_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          state <= reqWrite ? ST_WSET : ST_READ;
          cnt   <= reqWrite ? '0 : RD_LAST;
        end
        ST_WSET: begin
          state <= ST_WPULSE;
          cnt   <= WE_LAST;
        end
        ST_WPULSE: begin
          if (cntZero) begin
            state <= ST_WREC;
            cnt   <= REC_LAST;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_WREC: begin
          if (cntZero) state <= ST_IDLE;
          else         cnt   <= cnt - 1'b1;
        end
        ST_READ: begin
          if (cntZero) state <= ST_GAP;
          else         cnt   <= cnt - 1'b1;
        end
        ST_GAP:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.ceN      = !((state == ST_WSET) || (state == ST_WPULSE) || (state == ST_READ));
    strobe.weN      = (state != ST_WPULSE);
    strobe.oeN      = (state != ST_READ);
    strobe.busDrive = (state == ST_WPULSE) || firstRec;
    strobe.capture  = (state == ST_READ) && cntZero;
    strobe.load     = accept;
  end

  assign rspDone = firstRec || (state == ST_GAP);

endmodule

// File: rtl/sram_seq_dp.sv
module sram_seq_dp
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [DATA_W-1:0] rspRdata,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [ADDR_W-1:0] memAddr,
  inout  wire  [DATA_W-1:0] memDq
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
    end else if (strobe.load) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               rdataQ <= '0;
    else if (strobe.capture) rdataQ <= memDq;
  end

  assign memDq    = strobe.busDrive ? wdataQ : {DATA_W{1'bz}};
  assign memAddr  = addrQ;
  assign memCeN   = strobe.ceN;
  assign memWeN   = strobe.weN;
  assign memOeN   = strobe.oeN;
  assign rspRdata = rdataQ;

endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W        = 13,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_PS = 10000,
  parameter int T_WP_NS       = 55,
  parameter int T_CW_NS       = 65,
  parameter int T_AW_NS       = 65,
  parameter int T_DW_NS       = 30,
  parameter int T_WC_NS       = 70,
  parameter int T_WR_NS       = 15,
  parameter int T_RC_NS       = 70,
  parameter int T_AA_NS       = 70,
  parameter int T_ACE_NS      = 70,
  parameter int T_OE_NS       = 35
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              writeProtect,
  output logic              rspDone,
  output logic [DATA_W-1:0] rspRdata,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [ADDR_W-1:0] memAddr,
  inout  wire  [DATA_W-1:0] memDq
);

  localparam int P = CLK_PERIOD_PS;
  localparam int WE_CYC = maxOf(maxOf(cyclesFor(T_WP_NS, P), cyclesFor(T_CW_NS, P) - 1),
                                maxOf(cyclesFor(T_AW_NS, P) - 1, cyclesFor(T_DW_NS, P)));
  localparam int REC_CYC = maxOf(cyclesFor(T_WR_NS, P), cyclesFor(T_WC_NS, P) - 1 - WE_CYC);
  localparam int RD_CYC = maxOf(maxOf(cyclesFor(T_RC_NS, P), cyclesFor(T_AA_NS, P)),
                                maxOf(cyclesFor(T_ACE_NS, P), cyclesFor(T_OE_NS, P)));
  localparam int CNT_W = $clog2(maxOf(maxOf(WE_CYC, REC_CYC), RD_CYC) + 1);

  seqStrobe_t strobe;

  sram_seq_ctrl #(
    .WE_CYC (WE_CYC),
    .REC_CYC(REC_CYC),
    .RD_CYC (RD_CYC),
    .CNT_W  (CNT_W)
  ) i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqWrite    (reqWrite),
    .writeProtect(writeProtect),
    .reqReady    (reqReady),
    .rspDone     (rspDone),
    .strobe      (strobe)
  );

  sram_seq_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .rspRdata(rspRdata),
    .memCeN  (memCeN),
    .memWeN  (memWeN),
    .memOeN  (memOeN),
    .memAddr (memAddr),
    .memDq   (memDq)
  );

endmodule

// File: rtl/sram_seq_chk.sv
module sram_seq_chk #(
  parameter int ADDR_W = 13,
  parameter int WE_MIN = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              writeProtect,
  input logic              rspDone,
  input logic              memCeN,
  input logic              memWeN,
  input logic              memOeN,
  input logic [ADDR_W-1:0] memAddr
);

  logic [7:0] weRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        weRun <= '0;
    else if (!memWeN) weRun <= (weRun == 8'hFF) ? weRun : weRun + 1'b1;
    else              weRun <= '0;
  end

  AST_WE_INSIDE_CE: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> !memCeN); // R3

  AST_CE_LEADS_WE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memWeN) |-> $past(!memCeN)); // R3

  AST_OE_OFF_IN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> memOeN); // R3

  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (weRun >= 8'(WE_MIN))); // R10

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && $past(!memCeN)) |-> $stable(memAddr)); // R6

  AST_NO_ACCEPT_WP: assert property (@(posedge clk) disable iff (!rstN)
    writeProtect |-> !reqReady); // R2

  AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone); // R8

  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |-> (memCeN && memWeN && memOeN)); // R9

endmodule

bind sram_seq sram_seq_chk #(
  .ADDR_W(ADDR_W),
  .WE_MIN(WE_CYC)
) i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .reqReady    (reqReady),
  .writeProtect(writeProtect),
  .rspDone     (rspDone),
  .memCeN      (memCeN),
  .memWeN      (memWeN),
  .memOeN      (memOeN),
  .memAddr     (memAddr)
);

// File: tb/test_sram_seq.sv
module test_sram_seq;

  localparam int CLK_NS   = 10;
  localparam int WATCHDOG = 20000;

  // cycle counts worked out from the nanosecond figures, rounded up
  function automatic int nsCyc(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction
  localparam int E_WE  = 6;   // max(55/10->6, 65/10->7 -1, 65->7 -1, 30->3)
  localparam int E_REC = 2;   // max(15->2, 7-1-6)
  localparam int E_RD  = 7;   // max(70,70,70,35 -> 7,7,7,4)

  logic        clk = 0;
  logic        rstN = 0;
  logic        reqValid = 0, reqWrite = 0, writeProtect = 0;
  logic [12:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        reqReady, rspDone, memCeN, memWeN, memOeN;
  logic [7:0]  rspRdata;
  logic [12:0] memAddr;
  wire  [7:0]  memDq;

  logic [7:0] memArr [int];
  logic [7:0] shadow [int];
  logic       memDrv = 0;
  logic [7:0] memOut = '0;

  assign memDq = memDrv ? memOut : 8'bz;

  always #(CLK_NS/2) clk = ~clk;

  sram_seq i_sram_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .writeProtect(writeProtect), .rspDone(rspDone), .rspRdata(rspRdata),
    .memCeN(memCeN), .memWeN(memWeN), .memOeN(memOeN), .memAddr(memAddr),
    .memDq(memDq)
  );

  // behavioural memory: latches while both strobes are low, drives when reading
  always @(negedge clk) begin
    if (!memCeN && !memWeN) memArr[int'(memAddr)] = memDq;
    memDrv = !memCeN && !memOeN && memWeN;
    memOut = memArr.exists(int'(memAddr)) ? memArr[int'(memAddr)] : 8'h00;
  end

  typedef struct {
    bit ceN, weN, oeN, drv, done, busy, isRead;
    logic [12:0] addr;
    logic [7:0]  data;
  } expCyc_t;

  expCyc_t expQ[$];
  int nChecks = 0;
  int nFails  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic finishRun;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  function automatic expCyc_t mk(bit ce, bit we, bit oe, bit drv, bit done,
                                 bit busy, bit rd, logic [12:0] a, logic [7:0] d);
    expCyc_t e;
    e.ceN = ce; e.weN = we; e.oeN = oe; e.drv = drv; e.done = done;
    e.busy = busy; e.isRead = rd; e.addr = a; e.data = d;
    return e;
  endfunction

  task automatic pushAccess(input bit w, input logic [12:0] a, input logic [7:0] d);
    logic [7:0] rd;
    if (w) begin
      shadow[int'(a)] = d;
      expQ.push_back(mk(0, 1, 1, 0, 0, 1, 0, a, d));
      for (int i = 0; i < E_WE; i++) expQ.push_back(mk(0, 0, 1, 1, 0, 1, 0, a, d));
      expQ.push_back(mk(1, 1, 1, 1, 1, 1, 0, a, d));
      for (int i = 1; i < E_REC; i++) expQ.push_back(mk(1, 1, 1, 0, 0, 1, 0, a, d));
    end else begin
      rd = shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00;
      for (int i = 0; i < E_RD; i++) expQ.push_back(mk(0, 1, 0, 0, 0, 1, 1, a, rd));
      expQ.push_back(mk(1, 1, 1, 0, 1, 1, 1, a, rd));
    end
  endtask

  // one clock of the reference: compare this cycle, then drive the next inputs
  task automatic step(input bit v, input bit w, input logic [12:0] a,
                      input logic [7:0] d, input bit wp, output bit acc);
    expCyc_t cur;
    bit expReady;
    @(negedge clk);
    #1;
    if (expQ.size() > 0) cur = expQ.pop_front();
    else                 cur = mk(1, 1, 1, 0, 0, 0, 0, '0, '0);
    chk(memCeN == cur.ceN, "R3,R7,R9", "memCeN", memCeN, cur.ceN);
    chk(memWeN == cur.weN, "R3,R5,R10", "memWeN", memWeN, cur.weN);
    chk(memOeN == cur.oeN, "R3,R7", "memOeN", memOeN, cur.oeN);
    chk(rspDone == cur.done, cur.isRead ? "R8" : "R11", "rspDone", rspDone, cur.done);
    if (cur.done && cur.isRead)
      chk(rspRdata == cur.data, "R8", "rspRdata", rspRdata, cur.data);
    if (!cur.ceN)
      chk(memAddr == cur.addr, "R6", "memAddr", memAddr, cur.addr);
    if (cur.drv)
      chk(memDq == cur.data, "R4", "memDq", memDq, cur.data);
    reqValid = v; reqWrite = w; reqAddr = a; reqWdata = d; writeProtect = wp;
    #1;
    expReady = !cur.busy && !wp;
    chk(reqReady == expReady, "R2", "reqReady", reqReady, expReady);
    acc = v && expReady;
    if (acc) pushAccess(w, a, d);
  endtask

  task automatic doReq(input bit w, input logic [12:0] a, input logic [7:0] d);
    bit acc;
    acc = 0;
    for (int i = 0; i < 100 && !acc; i++) step(1, w, a, d, 0, acc);
  endtask

  task automatic idle(input int n);
    bit acc;
    for (int i = 0; i < n; i++) step(0, 0, 13'h0ABC, 8'hE7, 0, acc);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    bit acc;
    repeat (3) @(negedge clk);
    chk(memCeN && memWeN && memOeN, "R1", "strobes in reset", {memCeN, memWeN, memOeN}, 3'b111);
    chk(rspDone == 0, "R1", "rspDone in reset", rspDone, 0);
    chk(reqReady == 1, "R1", "reqReady in reset", reqReady, 1);
    rstN = 1;
    idle(2);
    chk(nsCyc(55) == E_WE && nsCyc(15) == E_REC && nsCyc(70) == E_RD, "R10",
        "derived counts", nsCyc(55), E_WE);

    // back-to-back writes, edge addresses and data patterns (R3, R4, R5)
    doReq(1, 13'h0000, 8'hA5);
    doReq(1, 13'h1FFF, 8'h5A);
    doReq(1, 13'h0123, 8'hFF);
    doReq(1, 13'h0124, 8'h00);
    idle(3);
    // reads back (R7, R8)
    doReq(0, 13'h0000, 8'h11);
    doReq(0, 13'h1FFF, 8'h22);
    doReq(0, 13'h0123, 8'h33);
    doReq(0, 13'h0124, 8'h44);
    doReq(0, 13'h0777, 8'h55);
    // write then read of the same word with no gap on the request side (R9)
    doReq(1, 13'h0777, 8'h3C);
    doReq(0, 13'h0777, 8'h00);
    // protect raised during a write: it completes, nothing new is taken (R2)
    doReq(1, 13'h0200, 8'h11);
    for (int i = 0; i < 15; i++) step(1, 1, 13'h0201, 8'h22, 1, acc);
    doReq(1, 13'h0201, 8'h22);
    // protect during a read in flight
    doReq(0, 13'h0200, 8'h00);
    for (int i = 0; i < 4; i++) step(1, 0, 13'h0201, 8'h00, 1, acc);
    doReq(0, 13'h0201, 8'h00);
    // overwrite and rspRdata holding across a write (R8)
    doReq(1, 13'h0000, 8'hC3);
    doReq(0, 13'h0000, 8'h00);
    doReq(1, 13'h0001, 8'h96);
    idle(12);
    chk(rspRdata == 8'hC3, "R8", "rspRdata held", rspRdata, 8'hC3);
    finishRun();
  end

endmodule